// File: doc/BRIEF.md
# Inbound Byte-to-Halfword Packer

This block sits on the receive side of an 8-bit bus controller while data flows inbound. Bytes arrive on a valid/ready stream. They are stored in a small byte FIFO and handed to a DMA reader as 16-bit words. The first byte of each pair goes in the low half of the word.

A transfer counter limits each inbound run. Software programs a preset, and a start command copies the preset into the counter. The counter then drops by one for every byte taken in. When it reaches zero, the stream input stops accepting bytes. Complete words keep draining to the DMA side. If a single byte is left over, a configuration bit chooses what happens to it:
- **Hold mode (reset default):** the byte stays in the FIFO and the interrupt is raised. Software writes a pad byte, then reads the pair back as one word.
- **Auto-pad mode:** the block sends the byte to the DMA side with a zero high half. The interrupt is raised only after that word has been taken.

The interrupt is a level that software clears with a write-one-to-clear. If a run stops early, software can add the counter value to the FIFO occupancy to get the number of bytes still outstanding.

Top module: `rx_byte_packer`

## Requirements
- R1: After reset, `irq`, `in_ready` and `word_valid` are 0. The occupancy read (address 3) returns 0 and the configuration read (address 2) returns 0.
- R2: Writes to address 0 set the low byte of the count preset, and writes to address 1 set the high byte. Writing bit 0 = 1 at address 3 loads the counter from the preset, empties the FIFO and starts a run, after which `in_ready` is 1 whenever the counter is non-zero and the FIFO has room. Reads of address 0 and address 1 return the counter's low and high bytes.
- R3: Each accepted input byte lowers the counter by exactly one. While the counter is zero, `in_ready` is 0.
- R4: `word_valid` is asserted while a run holds two or more bytes. `word_data` then carries the older byte in bits 7:0 and the next byte in bits 15:8. A `word_valid`/`word_ready` handshake removes both bytes.
- R5: Address 3 reads the FIFO occupancy as a value from 0 to 16. With 16 bytes stored, `in_ready` is 0.
- R6: At any point in a run, the counter plus the occupancy equals the preset minus twice the number of words taken.
- R7: In hold mode (configuration bit 7 = 0), an odd last byte is never offered on `word_valid`. `irq` rises while that byte is still held, with occupancy 1. `irq` stays 0 until the counter is zero.
- R8: A write to address 5 pushes its data byte into the FIFO. A read of address 5 returns {second byte, first byte} and removes both bytes when at least two are held.
- R9: In auto-pad mode (configuration bit 7 = 1), an odd last byte is delivered as {8'h00, byte}. `irq` rises only after that word has been handshaken.
- R10: For an even count, in either mode, `irq` stays 0 until the final word has been handshaken and then rises within a few cycles.
- R11: `irq` is a level that stays 1 until a write with bit 0 = 1 to address 4. A write of 0 there leaves it set.
- R12: Configuration bit 7 is cleared by every reset, even after it has been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inbound byte present |
| in_data | input | 8 | Inbound byte |
| in_ready | output | 1 | Block accepts the inbound byte |
| word_valid | output | 1 | Packed word offered to DMA side |
| word_ready | input | 1 | DMA side takes the word |
| word_data | output | 16 | Packed word, older byte low |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_re | input | 1 | CPU register read strobe (pops at address 5) |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 16 | CPU read data, combinational from address |
| irq | output | 1 | Level interrupt |

## Verification
The corruptions most likely to hide inside this block are in the counter, in the FIFO pointers and in the end-of-run state machine.
- **Counter slip:** the stream stops too early or too late. The R6 sum read back over the CPU port shows the error on the very next read.
- **Pointer or byte-order error:** the next handshaken word is wrong, so the first word after the fault is caught.
- **End-of-run fault:** `irq` rises before the final word has been taken, an odd byte leaks to the DMA side in hold mode, or the padded high half is non-zero. The bench watches `irq` on every cycle of a run, so an early interrupt is caught on the cycle it appears.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

   // CPU register map (3-bit address)
   localparam logic [2:0] A_CNT_LO = 3'd0;  // W: preset low byte   R: counter low byte
   localparam logic [2:0] A_CNT_HI = 3'd1;  // W: preset high byte  R: counter high byte
   localparam logic [2:0] A_CFG    = 3'd2;  // RW: odd-byte policy bit
   localparam logic [2:0] A_CTRL   = 3'd3;  // W: bit0 start run    R: FIFO occupancy
   localparam logic [2:0] A_IRQ    = 3'd4;  // W: bit0 clears irq   R: bit0 irq
   localparam logic [2:0] A_DATA   = 3'd5;  // W: pad byte push     R: word pop

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } rbp_state_e;

endpackage

// File: rtl/rbp_byte_fifo.sv
module rbp_byte_fifo #(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int OCC_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [7:0]       push_data,
   input  logic [1:0]       pop_n,
   output logic [7:0]       head0,
   output logic [7:0]       head1,
   output logic [OCC_W-1:0] occ,
   output logic             full
);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q;
   logic [PTR_W-1:0] rd_ptr_q;
   logic [PTR_W-1:0] rd_ptr_nx1;
   logic [OCC_W-1:0] occ_q;

   assign rd_ptr_nx1 = rd_ptr_q + PTR_W'(1);
   assign head0      = mem[rd_ptr_q];
   assign head1      = mem[rd_ptr_nx1];
   assign occ        = occ_q;
   assign full       = (occ_q == OCC_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (push && !flush) begin
         mem[wr_ptr_q] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         occ_q    <= '0;
      end else if (flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         occ_q    <= '0;
      end else begin
         if (push) begin
            wr_ptr_q <= wr_ptr_q + PTR_W'(1);
         end
         rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n);
         occ_q    <= occ_q + OCC_W'(push) - OCC_W'(pop_n);
      end
   end

endmodule

// File: rtl/rbp_xfer_counter.sv
module rbp_xfer_counter #(
   parameter int CNT_W = 16,
   localparam int LANES = (CNT_W + 7) / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_we,
   input  logic [7:0]       wdata,
   input  logic             load,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             zero
);

   logic [CNT_W-1:0] preset;
   logic [CNT_W-1:0] count_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LO = g * 8;
      localparam int HI = (LO + 8 > CNT_W) ? CNT_W - 1 : LO + 7;
      logic [HI-LO:0] lane_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (lane_we[g]) begin
            lane_q <= wdata[HI-LO:0];
         end
      end

      assign preset[HI:LO] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= preset;
      end else if (dec && count_q != '0) begin
         count_q <= count_q - CNT_W'(1);
      end
   end

   assign count = count_q;
   assign zero  = (count_q == '0);

endmodule

// File: rtl/rbp_ctrl.sv
module rbp_ctrl
   import rbp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cnt_zero,
   input  logic occ_is0,
   input  logic occ_is1,
   input  logic autopad,
   input  logic irq_clr,
   output logic running,
   output logic irq
);

   rbp_state_e state_q;
   logic       irq_q;
   logic       end_even;
   logic       end_hold;
   logic       irq_set;

   // Run is over: everything drained, or one byte left under hold policy
   assign end_even = (state_q == ST_RUN) && cnt_zero && occ_is0;
   assign end_hold = (state_q == ST_RUN) && cnt_zero && occ_is1 && !autopad;
   assign irq_set  = !start && (end_even || end_hold);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else if (start) begin
         state_q <= ST_RUN;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (end_even) begin
                  state_q <= ST_IDLE;
               end else if (end_hold) begin
                  state_q <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (occ_is0) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (irq_set) begin
         irq_q <= 1'b1;
      end else if (irq_clr) begin
         irq_q <= 1'b0;
      end
   end

   assign running = (state_q == ST_RUN);
   assign irq     = irq_q;

endmodule

// File: rtl/rx_byte_packer.sv
module rx_byte_packer
   import rbp_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int FIFO_DEPTH  = 16,
   parameter int AUTOPAD_BIT = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        word_valid,
   input  logic        word_ready,
   output logic [15:0] word_data,
   input  logic        cpu_we,
   input  logic        cpu_re,
   input  logic [2:0]  cpu_addr,
   input  logic [7:0]  cpu_wdata,
   output logic [15:0] cpu_rdata,
   output logic        irq
);

   localparam int OCC_W = $clog2(FIFO_DEPTH) + 1;
   localparam int LANES = (CNT_W + 7) / 8;

   // Elaboration-time parameter checks
   if (FIFO_DEPTH < 4 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 4");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 9..16 to fit two byte registers");
   end
   if (AUTOPAD_BIT < 0 || AUTOPAD_BIT > 7) begin : g_bad_bit
      $error("AUTOPAD_BIT must select a bit of the config byte");
   end

   // CPU decode
   logic start, irq_clr, pad_wr, word_rd, cfg_wr;
   logic [LANES-1:0] lane_we;

   assign start   = cpu_we && (cpu_addr == A_CTRL) && cpu_wdata[0];
   assign irq_clr = cpu_we && (cpu_addr == A_IRQ)  && cpu_wdata[0];
   assign pad_wr  = cpu_we && (cpu_addr == A_DATA);
   assign word_rd = cpu_re && (cpu_addr == A_DATA);
   assign cfg_wr  = cpu_we && (cpu_addr == A_CFG);
   assign lane_we = {cpu_we && (cpu_addr == A_CNT_HI), cpu_we && (cpu_addr == A_CNT_LO)};

   // Configuration: odd-byte policy
   logic autopad_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         autopad_q <= 1'b0;
      end else if (cfg_wr) begin
         autopad_q <= cpu_wdata[AUTOPAD_BIT];
      end
   end

   // Datapath wiring
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;
   logic [OCC_W-1:0] occ;
   logic             fifo_full;
   logic [7:0]       head0, head1;
   logic             running;
   logic             occ_ge2, occ_is1, occ_is0;
   logic             pair_ok, pad_ok, dma_fire, in_fire, cpu_pop2;
   logic             push;
   logic [7:0]       push_data;
   logic [1:0]       pop_n;

   assign occ_ge2 = (occ >= OCC_W'(2));
   assign occ_is1 = (occ == OCC_W'(1));
   assign occ_is0 = (occ == '0);

   assign in_ready = running && !cnt_zero && !fifo_full;
   assign in_fire  = in_valid && in_ready;

   assign pair_ok    = running && occ_ge2;
   assign pad_ok     = running && autopad_q && cnt_zero && occ_is1;
   assign word_valid = pair_ok || pad_ok;
   assign word_data  = pad_ok ? {8'h00, head0} : {head1, head0};
   assign dma_fire   = word_valid && word_ready;

   assign cpu_pop2  = word_rd && occ_ge2 && !dma_fire;
   assign push      = in_fire || (pad_wr && !fifo_full);
   assign push_data = in_fire ? in_data : cpu_wdata;

   always_comb begin
      if ((dma_fire && pair_ok) || cpu_pop2) begin
         pop_n = 2'd2;
      end else if (dma_fire && pad_ok) begin
         pop_n = 2'd1;
      end else begin
         pop_n = 2'd0;
      end
   end

   rbp_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (start),
      .push      (push),
      .push_data (push_data),
      .pop_n     (pop_n),
      .head0     (head0),
      .head1     (head1),
      .occ       (occ),
      .full      (fifo_full)
   );

   rbp_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .wdata   (cpu_wdata),
      .load    (start),
      .dec     (in_fire),
      .count   (cnt_q),
      .zero    (cnt_zero)
   );

   rbp_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cnt_zero (cnt_zero),
      .occ_is0  (occ_is0),
      .occ_is1  (occ_is1),
      .autopad  (autopad_q),
      .irq_clr  (irq_clr),
      .running  (running),
      .irq      (irq)
   );

   // CPU read mux
   logic [15:0] cnt_ext;
   logic [7:0]  cfg_byte;
   assign cnt_ext  = 16'(cnt_q);
   assign cfg_byte = 8'(autopad_q) << AUTOPAD_BIT;

   always_comb begin
      unique case (cpu_addr)
         A_CNT_LO: cpu_rdata = {8'h00, cnt_ext[7:0]};
         A_CNT_HI: cpu_rdata = {8'h00, cnt_ext[15:8]};
         A_CFG:    cpu_rdata = {8'h00, cfg_byte};
         A_CTRL:   cpu_rdata = 16'(occ);
         A_IRQ:    cpu_rdata = {15'h0000, irq};
         A_DATA:   cpu_rdata = {head1, head0};
         default:  cpu_rdata = 16'h0000;
      endcase
   end

endmodule

// File: rtl/rbp_checker.sv
module rbp_checker
   import rbp_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int OCC_W = 5,
   parameter int DEPTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             word_valid,
   input logic [15:0]      word_data,
   input logic             irq,
   input logic             cpu_we,
   input logic [2:0]       cpu_addr,
   input logic [7:0]       cpu_wdata,
   input logic [CNT_W-1:0] cnt,
   input logic [OCC_W-1:0] occ
);

   logic start_wr, clr_wr;
   assign start_wr = cpu_we && (cpu_addr == A_CTRL) && cpu_wdata[0];
   assign clr_wr   = cpu_we && (cpu_addr == A_IRQ) && cpu_wdata[0];

   assert_stop_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> !in_ready);

   assert_dec_per_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !start_wr) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(DEPTH));

   assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == OCC_W'(DEPTH)) |-> !in_ready);

   assert_word_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (occ != '0));

   assert_pad_high_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && cnt == '0 && occ == OCC_W'(1)) |-> (word_data[15:8] == 8'h00));

   assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_wr) |=> irq);

endmodule

bind rx_byte_packer rbp_checker #(
   .CNT_W (CNT_W),
   .OCC_W (OCC_W),
   .DEPTH (FIFO_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .word_valid (word_valid),
   .word_data  (word_data),
   .irq        (irq),
   .cpu_we     (cpu_we),
   .cpu_addr   (cpu_addr),
   .cpu_wdata  (cpu_wdata),
   .cnt        (cnt_q),
   .occ        (occ)
);

// File: tb/rx_byte_packer_tb.sv
module rx_byte_packer_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_ready;
   logic [7:0]  in_data;
   logic        word_valid, word_ready;
   logic [15:0] word_data;
   logic        cpu_we, cpu_re;
   logic [2:0]  cpu_addr;
   logic [7:0]  cpu_wdata;
   logic [15:0] cpu_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0] stim [64];

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_byte_packer u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected packed word k of an n-byte run
   function automatic logic [15:0] exp_word(int k, int n);
      if (2 * k + 1 < n) return {stim[2 * k + 1], stim[2 * k]};
      return {8'h00, stim[2 * k]};
   endfunction

   task automatic cpu_wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic cpu_rd(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      cpu_re = 1'b1; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_re = 1'b0;
   endtask

   task automatic start_run(int n, bit pad);
      cpu_wr(3'd2, pad ? 8'h80 : 8'h00);
      cpu_wr(3'd0, 8'(n));
      cpu_wr(3'd1, 8'(n >> 8));
      for (int i = 0; i < 64; i++) stim[i] = 8'($urandom);
      cpu_wr(3'd3, 8'h01);
   endtask

   task automatic wait_irq();
      for (int i = 0; i < 6; i++) begin
         if (irq) break;
         @(negedge clk);
      end
   endtask

   task automatic run_xfer(int n, bit pad, int vprob, int rprob);
      int sent = 0, got = 0, cyc = 0;
      int exp_words = n / 2 + ((pad && (n % 2 == 1)) ? 1 : 0);
      bit early = 0;
      logic [15:0] rd;
      logic [7:0] pb;
      start_run(n, pad);
      while (!(sent == n && got == exp_words) && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         in_valid   = (sent < n) && (($urandom % 100) < vprob);
         in_data    = stim[sent];
         word_ready = (($urandom % 100) < rprob);
         #1;
         if (irq) early = 1;
         if (in_valid && in_ready) sent++;
         if (word_valid && word_ready) begin
            chk("R4", "packed word", word_data, exp_word(got, n));
            got++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; word_ready = 1'b0;
      chk("R10", "irq before final word", early, 0);
      wait_irq();
      chk(pad ? "R9" : ((n % 2 == 1) ? "R7" : "R10"), "irq after run", irq, 1);
      chk("R3", "in_ready at count zero", in_ready, 0);
      if (!pad && (n % 2 == 1)) begin
         chk("R7", "odd byte not offered", word_valid, 0);
         cpu_rd(3'd3, rd);
         chk("R7", "held occupancy", rd, 1);
         pb = 8'($urandom);
         cpu_wr(3'd5, pb);
         cpu_rd(3'd5, rd);
         chk("R8", "padded pair", rd, {pb, stim[n - 1]});
         cpu_rd(3'd3, rd);
         chk("R8", "occupancy after pop", rd, 0);
      end
      cpu_rd(3'd0, rd);
      chk("R3", "counter at end", rd, 0);
      cpu_wr(3'd4, 8'h00);
      chk("R11", "irq kept on zero write", irq, 1);
      cpu_wr(3'd4, 8'h01);
      chk("R11", "irq cleared", irq, 0);
   endtask

   initial begin
      logic [15:0] rd;
      logic [15:0] c, o;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; word_ready = 1'b0;
      cpu_we = 1'b0; cpu_re = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1", "irq", irq, 0);
      chk("R1", "in_ready", in_ready, 0);
      chk("R1", "word_valid", word_valid, 0);
      cpu_rd(3'd3, rd); chk("R1", "occupancy", rd, 0);
      cpu_rd(3'd2, rd); chk("R1", "config", rd, 0);

      // R2: two-byte preset, counter readback
      start_run(16'h0123, 0);
      cpu_rd(3'd0, rd); chk("R2", "counter low", rd, 16'h23);
      cpu_rd(3'd1, rd); chk("R2", "counter high", rd, 16'h01);
      #1 chk("R2", "in_ready after start", in_ready, 1);

      // R5: fill to capacity with DMA stalled
      start_run(20, 0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); in_valid = 1'b1; in_data = stim[i];
      end
      @(negedge clk); in_valid = 1'b0; #1;
      chk("R5", "in_ready when full", in_ready, 0);
      cpu_rd(3'd3, rd); chk("R5", "occupancy full", rd, 16);
      cpu_rd(3'd0, rd); chk("R3", "counter after 16 bytes", rd, 4);

      // R6: early stop accounting
      start_run(10, 0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); in_valid = 1'b1; in_data = stim[i];
      end
      @(negedge clk); in_valid = 1'b0;
      cpu_rd(3'd0, c); cpu_rd(3'd3, o);
      chk("R6", "counter+occ before drain", c + o, 10);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); word_ready = 1'b1; #1;
         chk("R4", "drain word", word_data, exp_word(k, 10));
      end
      @(negedge clk); word_ready = 1'b0;
      cpu_rd(3'd0, c); cpu_rd(3'd3, o);
      chk("R6", "counter+occ after two words", c + o, 6);

      // Directed corners
      run_xfer(1, 0, 100, 100);
      run_xfer(1, 1, 100, 100);
      run_xfer(2, 0, 100, 100);
      run_xfer(17, 1, 100, 0 + 100);
      run_xfer(33, 0, 100, 20);

      // Constrained random runs
      for (int t = 0; t < 12; t++) begin
         run_xfer(1 + int'($urandom % 40), bit'($urandom % 2),
                  30 + int'($urandom % 71), 30 + int'($urandom % 71));
      end

      // R12: config bit cleared by reset
      cpu_wr(3'd2, 8'h80);
      cpu_rd(3'd2, rd); chk("R12", "config set", rd, 16'h80);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cpu_rd(3'd2, rd); chk("R12", "config after reset", rd, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule